// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Hub

The hub lets any core in a multicore system interrupt any other core through a small memory-mapped register file. Each core has its own 8-byte window with two 32-bit words: a command word and a status word. A core sends a message by writing its own command word. The write carries a destination core index and a 16-bit payload. This sets a pending flag on the destination and asserts that core's interrupt line. The destination reads its status word to get the flag, the payload and the index of the sender. It then clears the flag by writing an acknowledge command to its own command word.

The number of cores is a parameter. Accesses are whole 32-bit words, with bit 31 as the most significant bit, on one simple read/write port. Only one access happens per cycle. Read data is registered and appears on the cycle after the read strobe.

Top module: `xirq_hub`

## Requirements
- R1: Addresses are byte addresses. The command word of core c is at c*8 and its status word is at c*8+4. Any address at or above NUM_CORES*8, or with address bits 1:0 not zero, is unmapped.
- R2: A write to core s's command word with bit 30 (generate) set and a destination index d < NUM_CORES in bits 29:16 asserts irq_o[d]. From the next cycle, bit 30 of core d's status word reads 1.
- R3: A generate latches the payload (command bits 15:0) into status bits 15:0 and the sender index s into status bits 29:16. Status bit 31 always reads 0.
- R4: A write to core c's own command word with bit 31 (acknowledge) set clears core c's pending flag and irq_o[c] from the next cycle.
- R5: When one write has both bit 31 and bit 30 set, the acknowledge applies to the writing core and the generate applies to the destination core.
- R6: When a generate and an acknowledge reach the same core in the same write (a core generating to itself with acknowledge also set), the generate wins. The flag stays set and the new payload and source are latched.
- R7: A generate whose destination index is at or above NUM_CORES changes no pending flag, payload or source.
- R8: A generate to a core that is already pending overwrites the latched payload and source and leaves the flag set.
- R9: Read data is returned on the cycle after the read strobe. Reads of command words and of unmapped addresses return zero.
- R10: Writes to status words and to unmapped addresses change no state.
- R11: Reset clears every pending flag, every latched payload and source, and every interrupt output.
- R12: The interrupt outputs change only on the cycle after a write to a command word. Idle cycles and reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | NUM_CORES | One interrupt line per core, high while that core is pending |

## Verification
The bench sweeps every sender and destination pair of a four-core configuration, including a core sending to itself. Each payload is computed from both indices, so a swapped source field, a wrong destination or a stale payload shows up as a distinct mismatch. Because the sweep leaves destinations pending, later senders overwrite earlier ones, which separates overwrite from first-time set. Combined acknowledge-and-generate writes, one aimed at another core and one aimed at the writer itself, separate the two priority cases. Out-of-range destinations, misaligned and out-of-window addresses, and writes to status words check that these accesses leave the full status image and the interrupt lines unchanged.

// File: rtl/xirq_pkg.sv
// Shared field layout for the inter-processor interrupt hub.
// Assumes 32-bit words with bit 31 as the most significant bit.
package xirq_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_W   = 14;
    localparam int MSG_W   = 16;
    localparam int WIN_B   = 8;   // bytes per core window
    localparam int STAT_OF = 4;   // status word offset inside a window

    // Command word written by a core into its own window.
    typedef struct packed {
        logic             ack;   // bit 31: clear own pending flag
        logic             gen;   // bit 30: raise interrupt on dst
        logic [IDX_W-1:0] dst;   // bits 29:16
        logic [MSG_W-1:0] msg;   // bits 15:0
    } cmd_word_t;

    // Status word returned for a core.
    typedef struct packed {
        logic             zero;  // bit 31: always 0
        logic             pend;  // bit 30: interrupt pending
        logic [IDX_W-1:0] src;   // bits 29:16: sender index
        logic [MSG_W-1:0] msg;   // bits 15:0: latched payload
    } stat_word_t;

endpackage

// File: rtl/xirq_decode.sv
// Address decoder: splits a byte address into a core index and a word
// select, and flags whether it lands on a mapped command or status word.
// Assumes ADDR_W is large enough to reach NUM_CORES*8 bytes.
module xirq_decode #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6,
    parameter int CW        = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_cmd,
    output logic              hit_stat,
    output logic [CW-1:0]     core
);
    import xirq_pkg::*;

    localparam int MAP_BYTES = NUM_CORES * WIN_B;

    logic in_map;
    logic aligned;

    // Range and alignment test, then pick the word inside the window.
    always_comb begin
        in_map   = (32'(addr) < MAP_BYTES);
        aligned  = (addr[1:0] == 2'b00);
        hit_cmd  = in_map && aligned && !addr[2];
        hit_stat = in_map && aligned &&  addr[2];
        core     = CW'(addr >> 3);
    end

endmodule

// File: rtl/xirq_slot.sv
// Per-core pending slot: holds the pending flag, the sender index and the
// payload of the last generate. A generate has priority over an acknowledge
// arriving in the same cycle, so no interrupt is dropped.
module xirq_slot (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gen_i,
    input  logic                          ack_i,
    input  logic [xirq_pkg::IDX_W-1:0]    src_i,
    input  logic [xirq_pkg::MSG_W-1:0]    msg_i,
    output logic                          pend_o,
    output xirq_pkg::stat_word_t          stat_o
);
    import xirq_pkg::*;

    logic             pend_q;
    logic [IDX_W-1:0] src_q;
    logic [MSG_W-1:0] msg_q;

    // Pending state update: generate sets and latches, acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            src_q  <= '0;
            msg_q  <= '0;
        end else if (gen_i) begin
            pend_q <= 1'b1;
            src_q  <= src_i;
            msg_q  <= msg_i;
        end else if (ack_i) begin
            pend_q <= 1'b0;
        end
    end

    // Status image and interrupt line follow the stored state.
    always_comb begin
        stat_o.zero = 1'b0;
        stat_o.pend = pend_q;
        stat_o.src  = src_q;
        stat_o.msg  = msg_q;
        pend_o      = pend_q;
    end

endmodule

// File: rtl/xirq_rdport.sv
// Registered read port: returns the selected core's status word one cycle
// after the read strobe. Command words and unmapped addresses read as zero.
module xirq_rdport #(
    parameter int NUM_CORES = 4,
    parameter int CW        = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_i,
    input  logic                        hit_stat_i,
    input  logic [CW-1:0]               core_i,
    input  logic [NUM_CORES-1:0][31:0]  stat_all_i,
    output logic [31:0]                 rdata_o
);

    logic [31:0] sel_word;

    // Pick the addressed status word, or zero for anything else.
    always_comb begin
        sel_word = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (hit_stat_i && (core_i == CW'(c))) sel_word = stat_all_i[c];
        end
    end

    // Capture read data on the strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= sel_word;
    end

endmodule

// File: rtl/xirq_hub.sv
// Inter-processor interrupt hub, top level. Each core owns an 8-byte window:
// a command word at core*8 and a status word at core*8+4. A write to the
// command word can raise an interrupt on a destination core and/or clear the
// writer's own pending flag. Assumes one word access per cycle on the port.
module xirq_hub #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    import xirq_pkg::*;

    localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic                       hit_cmd;
    logic                       hit_stat;
    logic [CW-1:0]              core_sel;
    cmd_word_t                  cmd;
    logic                       wr_cmd;
    logic [IDX_W-1:0]           src_idx;
    logic [NUM_CORES-1:0]       gen_v;
    logic [NUM_CORES-1:0]       ack_v;
    logic [NUM_CORES-1:0]       pend_v;
    logic [NUM_CORES-1:0][31:0] stat_all;

    xirq_decode #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .CW        (CW)
    ) decode_i (
        .addr      (bus_addr),
        .hit_cmd   (hit_cmd),
        .hit_stat  (hit_stat),
        .core      (core_sel)
    );

    // Interpret the write data as a command from the addressed core.
    always_comb begin
        cmd     = cmd_word_t'(bus_wdata);
        wr_cmd  = bus_wr && hit_cmd;
        src_idx = IDX_W'(core_sel);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        stat_word_t slot_stat;

        // Route generate by destination field and acknowledge by writer.
        always_comb begin
            gen_v[c] = wr_cmd && cmd.gen && (cmd.dst == IDX_W'(c));
            ack_v[c] = wr_cmd && cmd.ack && (core_sel == CW'(c));
        end

        xirq_slot slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .gen_i  (gen_v[c]),
            .ack_i  (ack_v[c]),
            .src_i  (src_idx),
            .msg_i  (cmd.msg),
            .pend_o (pend_v[c]),
            .stat_o (slot_stat)
        );

        assign stat_all[c] = slot_stat;
    end

    xirq_rdport #(
        .NUM_CORES  (NUM_CORES),
        .CW         (CW)
    ) rdport_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .hit_stat_i (hit_stat),
        .core_i     (core_sel),
        .stat_all_i (stat_all),
        .rdata_o    (bus_rdata)
    );

    assign irq_o = pend_v;

endmodule

// File: rtl/xirq_hub_chk.sv
// Port-level checker for the interrupt hub, attached by bind below.
// It decodes addresses on its own and relates writes to later outputs.
module xirq_hub_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CORES-1:0] irq_o
);
    logic any_cmd_addr;
    logic stat_addr;
    logic bad_dst;

    always_comb begin
        any_cmd_addr = (32'(bus_addr) < NUM_CORES * 8) && (bus_addr[2:0] == 3'b000);
        stat_addr    = (32'(bus_addr) < NUM_CORES * 8) && (bus_addr[2:0] == 3'b100);
        bad_dst      = (32'(bus_wdata[29:16]) >= NUM_CORES);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // R2
        gen_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && any_cmd_addr && bus_wdata[30] && (32'(bus_wdata[29:16]) == c))
            |=> irq_o[c]);

        // R4
        ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (32'(bus_addr) == c * 8) && bus_wdata[31]
             && !(bus_wdata[30] && (32'(bus_wdata[29:16]) == c)))
            |=> !irq_o[c]);

        // R6
        gen_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (32'(bus_addr) == c * 8) && bus_wdata[31] && bus_wdata[30]
             && (32'(bus_wdata[29:16]) == c))
            |=> irq_o[c]);
    end

    // R12
    idle_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(irq_o));

    // R10
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !any_cmd_addr) |=> $stable(irq_o));

    // R7
    bad_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && any_cmd_addr && !bus_wdata[31] && bad_dst) |=> $stable(irq_o));

    // R9
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !stat_addr) |=> (bus_rdata == 32'h0));

    // R3
    stat_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rdata[31]);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

endmodule

bind xirq_hub xirq_hub_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/xirq_hub_tb.sv
`timescale 1ns/1ps
module xirq_hub_tb_top;
    localparam int NC = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_pend [NC];
    logic [13:0] m_src  [NC];
    logic [15:0] m_msg  [NC];

    xirq_hub #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cmd(input bit ack, input bit gen, input int dst, input logic [15:0] msg);
        return {ack, gen, 14'(dst), msg};
    endfunction

    function automatic logic [31:0] exp_stat(input int c);
        return {1'b0, m_pend[c], m_src[c], m_msg[c]};
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] v = '0;
        for (int c = 0; c < NC; c++) v[c] = m_pend[c];
        return v;
    endfunction

    // Compare the interrupt lines and every status word against the model.
    task automatic check_all(input string req);
        logic [31:0] rd;
        check32({req, " irq"}, 32'(irq_o), exp_irq());
        for (int c = 0; c < NC; c++) begin
            bus_read(AW'(c * 8 + 4), rd);
            check32({req, " status"}, rd, exp_stat(c));
        end
    endtask

    // Model of a command write from core s.
    task automatic send(input int s, input bit ack, input bit gen, input int dst, input logic [15:0] msg);
        bus_write(AW'(s * 8), cmd(ack, gen, dst, msg));
        if (ack) m_pend[s] = 1'b0;
        if (gen && dst < NC) begin
            m_pend[dst] = 1'b1;
            m_src[dst]  = 14'(s);
            m_msg[dst]  = msg;
        end
    endtask

    initial begin
        logic [31:0] rd;
        logic [NC-1:0] irq_before;
        for (int c = 0; c < NC; c++) begin
            m_pend[c] = 1'b0; m_src[c] = '0; m_msg[c] = '0;
        end
        repeat (3) @(negedge clk);
        // R11: state after reset
        check32("R11 irq after reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        check_all("R11 R1");

        // R2 R3 R8: every sender/destination pair; repeats overwrite
        for (int s = 0; s < NC; s++) begin
            for (int d = 0; d < NC; d++) begin
                send(s, 1'b0, 1'b1, d, 16'(s * 16'h1357 + d * 16'h0921 + 1));
                check_all("R2 R3 R8 sweep");
            end
        end

        // R4: each core acknowledges itself
        for (int c = 0; c < NC; c++) begin
            send(c, 1'b1, 1'b0, 0, 16'h0);
            check_all("R4 ack");
        end

        // R5: ack own flag and generate to another core in one write
        send(2, 1'b0, 1'b1, 1, 16'hA5A5);
        send(1, 1'b1, 1'b1, 2, 16'h5A5A);
        check_all("R5 ack+gen split");

        // R6: ack and generate both land on the writer
        send(0, 1'b0, 1'b1, 3, 16'h1111);
        send(3, 1'b1, 1'b1, 3, 16'h2222);
        check_all("R6 gen wins");

        // R7: destinations beyond the core count
        send(0, 1'b0, 1'b1, NC, 16'hDEAD);
        send(1, 1'b0, 1'b1, 14'h3FFF, 16'hBEEF);
        check_all("R7 bad dst");

        // R10: writes to status words, misaligned and out-of-window addresses
        bus_write(AW'(4), 32'hFFFF_FFFF);
        bus_write(AW'(3 * 8 + 4), cmd(1'b1, 1'b0, 0, 16'h0));
        bus_write(AW'(2), cmd(1'b0, 1'b1, 0, 16'h7777));
        bus_write(AW'(NC * 8), cmd(1'b0, 1'b1, 0, 16'h8888));
        bus_write(AW'(NC * 8 + 16), cmd(1'b1, 1'b1, 2, 16'h9999));
        check_all("R10 ignored writes");

        // R9: command words and unmapped addresses read zero
        bus_read(AW'(2 * 8), rd);
        check32("R9 cmd read", rd, 32'h0);
        bus_read(AW'(NC * 8 + 4), rd);
        check32("R9 unmapped read", rd, 32'h0);
        bus_read(AW'(3 * 8 + 6), rd);
        check32("R9 misaligned read", rd, 32'h0);

        // R12: idle cycles and reads leave the lines alone
        irq_before = irq_o;
        repeat (5) @(negedge clk);
        check32("R12 idle irq", 32'(irq_o), 32'(irq_before));
        bus_read(AW'(4), rd);
        check32("R12 read irq", 32'(irq_o), 32'(irq_before));

        // R11: reset in mid-run clears pending state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) begin
            m_pend[c] = 1'b0; m_src[c] = '0; m_msg[c] = '0;
        end
        check_all("R11 second reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule